// File: doc/BRIEF.md
# Packed Character String Compare Unit

This block compares two 128-bit operands that each hold a short string of packed characters. Each operand is read either as sixteen 8-bit elements or as eight 16-bit elements. A mode word picks one of four ways of combining the element comparisons into one result bit per element of operand B:
- match-any: membership of a B element in the set held by A
- match-each: position-by-position equality
- ordered: substring search for A inside B
- ranges: A holds inclusive bounds and each B element is tested against them

The valid part of each operand comes either from a length input or from the first zero element. The result bits may be inverted over the valid positions of B. They are then delivered either as a bit mask or as the position of the lowest set bit.

A request carries both operands, both lengths and the mode word, and is accepted on a valid/ready handshake. The answer comes back one clock later from a single output register, together with a flag that says whether any result bit was set. The register holds its contents until the consumer takes them. A new request may be accepted in the same cycle that the held answer is consumed.

Top module: `strCmpUnit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `outValid` is 0 and `inReady` is 1.
- R2: `inReady` equals `!outValid || outReady`. A request is accepted when `inValid && inReady`. Its answer is on `outResult`/`outMatch` with `outValid` high from the next clock edge. The answer stays unchanged while `outReady` is low, and `outValid` drops after a cycle with `outReady` high and no new acceptance.
- R3: `modeWord[0]` = 0 splits each operand into 16 elements of 8 bits; = 1 splits it into 8 elements of 16 bits. Element k occupies the lowest bits first (element 0 in bits [7:0] or [15:0]). In 16-bit mode, mask bits 15..8 are always 0.
- R4: `modeWord[3]` = 0 uses the explicit length inputs, each saturated to the element count. `modeWord[3]` = 1 makes an operand's length the index of its first zero element, or the element count if there is none. Element k is valid when k < length.
- R5: `modeWord[2:1]` = 0 (match-any): bit i is 1 when B element i is valid and equals some valid A element.
- R6: `modeWord[2:1]` = 1 (match-each): bit i is A[i]==B[i] when both are valid, 1 when both are invalid (within the element count), and 0 when exactly one is valid.
- R7: `modeWord[2:1]` = 3 (ordered): bit i is 1 when B element i is valid and, for every valid A element k with B element i+k valid, A[k]==B[i+k]. A match cut short by the end of B's valid part still counts. An empty A matches at every valid B position.
- R8: `modeWord[2:1]` = 2 (ranges): A elements (2p, 2p+1) form the inclusive unsigned bound pair p. A pair is used only when both of its elements are valid, so an odd trailing A element is ignored. Bit i is 1 when B element i is valid and lies within some used pair.
- R9: `modeWord[4]` = 1 inverts the result bits at the valid positions of B only, before the mask, index and flag are formed.
- R10: `modeWord[5]` = 1 puts the index of the lowest set result bit on `outResult`, zero-extended. When no bit is set, the index equals the element count (16, or 8 in 16-bit mode). `modeWord[5]` = 0 puts the bit mask on `outResult`.
- R11: `outMatch` is 1 exactly when at least one result bit (after inversion) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken this cycle |
| opA | input | 128 | Operand A: set, pattern or bound pairs |
| opB | input | 128 | Operand B: string being examined |
| lenA | input | 5 | Explicit length of A in elements |
| lenB | input | 5 | Explicit length of B in elements |
| modeWord | input | 6 | [0] element width, [2:1] aggregation, [3] implicit length, [4] invert, [5] index form |
| outValid | output | 1 | Answer held in output register |
| outReady | input | 1 | Consumer takes the answer |
| outResult | output | 16 | Bit mask or zero-extended index |
| outMatch | output | 1 | Some result bit set |

## Verification
Only `inReady` responds in the same cycle, to `outValid` and `outReady`. Mask, index and flag are due exactly one rising edge after the accepting cycle, and they stay unchanged for as long as the consumer stalls. The bench drives and samples on the falling edge. A behavioural model steps the expected valid bit and payload once per cycle, so every comparison lands one full edge after the acceptance that produced it. Random back-pressure on `outReady` covers the hold case, and directed strings cover partial tails, odd bound lists, empty strings and the no-match index.

// File: rtl/strCmpPkg.sv
package strCmpPkg;
  localparam int OPER_W   = 128;
  localparam int NARROW_W = 8;
  localparam int WIDE_W   = 16;
  localparam int MAX_EL   = OPER_W / NARROW_W;
  localparam int MIN_EL   = OPER_W / WIDE_W;
  localparam int PAIRS    = MAX_EL / 2;
  localparam int LEN_W    = $clog2(MAX_EL + 1);
  localparam int MODE_W   = 6;

  typedef enum logic [1:0] {
    AGG_ANY     = 2'd0,
    AGG_EACH    = 2'd1,
    AGG_RANGES  = 2'd2,
    AGG_ORDERED = 2'd3
  } aggMode_e;

  // LSB first: wideEl is modeWord[0]
  typedef struct packed {
    logic     outIndex;
    logic     negPol;
    logic     implicitLen;
    aggMode_e agg;
    logic     wideEl;
  } modeWord_t;

  typedef struct packed {
    logic load;
  } ctlStrobe_t;
endpackage

// File: rtl/strCmpCompare.sv
module strCmpCompare
  import strCmpPkg::*;
(
  input  logic [OPER_W-1:0] opA,
  input  logic [OPER_W-1:0] opB,
  input  logic [LEN_W-1:0]  lenA,
  input  logic [LEN_W-1:0]  lenB,
  input  modeWord_t         mode,
  output logic [MAX_EL-1:0] resBits,
  output logic [LEN_W-1:0]  resIndex
);
  logic [MAX_EL-1:0][WIDE_W-1:0] elA, elB;
  logic [MAX_EL-1:0][MAX_EL-1:0] eqM;
  logic [MAX_EL-1:0][MAX_EL-1:0] ordFail;
  logic [MAX_EL-1:0][PAIRS-1:0]  inRange;
  logic [MAX_EL-1:0] validA, validB, posMask, rawBits, finalBits;
  logic [LEN_W-1:0] numElem, zLenA, zLenB, effLenA, effLenB;

  assign numElem = mode.wideEl ? LEN_W'(MIN_EL) : LEN_W'(MAX_EL);

  // element extraction, zero-extended to the wide width
  for (genvar g = 0; g < MAX_EL; g++) begin : gElem
    logic [WIDE_W-1:0] wA, wB;
    if (g < MIN_EL) begin : gWide
      assign wA = opA[WIDE_W*g +: WIDE_W];
      assign wB = opB[WIDE_W*g +: WIDE_W];
    end else begin : gNone
      assign wA = '0;
      assign wB = '0;
    end
    assign elA[g] = mode.wideEl ? wA : {{(WIDE_W-NARROW_W){1'b0}}, opA[NARROW_W*g +: NARROW_W]};
    assign elB[g] = mode.wideEl ? wB : {{(WIDE_W-NARROW_W){1'b0}}, opB[NARROW_W*g +: NARROW_W]};
  end

  // implicit length: first zero element
  always_comb begin
    zLenA = numElem;
    zLenB = numElem;
    for (int j = MAX_EL - 1; j >= 0; j--) begin
      if (LEN_W'(j) < numElem && elA[j] == '0) zLenA = LEN_W'(j);
      if (LEN_W'(j) < numElem && elB[j] == '0) zLenB = LEN_W'(j);
    end
  end

  assign effLenA = mode.implicitLen ? zLenA : ((lenA > numElem) ? numElem : lenA);
  assign effLenB = mode.implicitLen ? zLenB : ((lenB > numElem) ? numElem : lenB);

  for (genvar g = 0; g < MAX_EL; g++) begin : gValid
    assign validA[g]  = LEN_W'(g) < effLenA;
    assign validB[g]  = LEN_W'(g) < effLenB;
    assign posMask[g] = LEN_W'(g) < numElem;
  end

  // full compare matrix, bound checks and ordered diagonals
  for (genvar gi = 0; gi < MAX_EL; gi++) begin : gRow
    for (genvar gj = 0; gj < MAX_EL; gj++) begin : gCol
      assign eqM[gi][gj] = elB[gi] == elA[gj];
      if (gi + gj < MAX_EL) begin : gDiag
        assign ordFail[gi][gj] = validA[gj] && validB[gi+gj] && !eqM[gi+gj][gj];
      end else begin : gOff
        assign ordFail[gi][gj] = 1'b0;
      end
    end
    for (genvar gp = 0; gp < PAIRS; gp++) begin : gPair
      assign inRange[gi][gp] = validA[2*gp+1] && (elB[gi] >= elA[2*gp]) && (elB[gi] <= elA[2*gp+1]);
    end
  end

  always_comb begin
    for (int i = 0; i < MAX_EL; i++) begin
      unique case (mode.agg)
        AGG_ANY:    rawBits[i] = validB[i] && (|(eqM[i] & validA));
        AGG_EACH:   rawBits[i] = posMask[i] && ((validA[i] && validB[i]) ? eqM[i][i]
                                                                        : (!validA[i] && !validB[i]));
        AGG_RANGES: rawBits[i] = validB[i] && (|inRange[i]);
        default:    rawBits[i] = validB[i] && !(|ordFail[i]);
      endcase
    end
  end

  assign finalBits = mode.negPol ? (rawBits ^ validB) : rawBits;

  always_comb begin
    resIndex = numElem;
    for (int i = MAX_EL - 1; i >= 0; i--) begin
      if (finalBits[i]) resIndex = LEN_W'(i);
    end
  end

  assign resBits = finalBits;
endmodule

// File: rtl/strCmpDatapath.sv
module strCmpDatapath
  import strCmpPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [OPER_W-1:0] opA,
  input  logic [OPER_W-1:0] opB,
  input  logic [LEN_W-1:0]  lenA,
  input  logic [LEN_W-1:0]  lenB,
  input  modeWord_t         mode,
  output logic [MAX_EL-1:0] outResult,
  output logic              outMatch
);
  logic [MAX_EL-1:0] resBits;
  logic [LEN_W-1:0]  resIndex;

  strCmpCompare u_cmp (
    .opA      (opA),
    .opB      (opB),
    .lenA     (lenA),
    .lenB     (lenB),
    .mode     (mode),
    .resBits  (resBits),
    .resIndex (resIndex)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outResult <= '0;
      outMatch  <= 1'b0;
    end else if (ctl.load) begin
      outResult <= mode.outIndex ? MAX_EL'(resIndex) : resBits;
      outMatch  <= |resBits;
    end
  end
endmodule

// File: rtl/strCmpControl.sv
module strCmpControl
  import strCmpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output ctlStrobe_t ctl
);
  logic accept;

  assign inReady  = !outValid || outReady;
  assign accept   = inValid && inReady;
  assign ctl.load = accept;

  always_ff @(posedge clk) begin
    if (!rstN)         outValid <= 1'b0;
    else if (accept)   outValid <= 1'b1;
    else if (outReady) outValid <= 1'b0;
  end
endmodule

// File: rtl/strCmpUnit.sv
module strCmpUnit
  import strCmpPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [OPER_W-1:0] opA,
  input  logic [OPER_W-1:0] opB,
  input  logic [LEN_W-1:0]  lenA,
  input  logic [LEN_W-1:0]  lenB,
  input  logic [MODE_W-1:0] modeWord,
  output logic              outValid,
  input  logic              outReady,
  output logic [MAX_EL-1:0] outResult,
  output logic              outMatch
);
  ctlStrobe_t ctl;

  strCmpControl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  strCmpDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .opA       (opA),
    .opB       (opB),
    .lenA      (lenA),
    .lenB      (lenB),
    .mode      (modeWord_t'(modeWord)),
    .outResult (outResult),
    .outMatch  (outMatch)
  );
endmodule

// File: rtl/strCmpChecker.sv
module strCmpChecker
  import strCmpPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [MODE_W-1:0] modeWord,
  input logic              outValid,
  input logic              outReady,
  input logic [MAX_EL-1:0] outResult,
  input logic              outMatch
);
  logic             lastWide, lastIndex;
  logic [LEN_W-1:0] lastCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastWide  <= 1'b0;
      lastIndex <= 1'b0;
    end else if (inValid && inReady) begin
      lastWide  <= modeWord[0];
      lastIndex <= modeWord[5];
    end
  end

  assign lastCount = lastWide ? LEN_W'(MIN_EL) : LEN_W'(MAX_EL);

  AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outResult) && $stable(outMatch)); // R2
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady); // R2
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady); // R1
  AST_WIDE_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    outValid && lastWide && !lastIndex |-> outResult[MAX_EL-1:MIN_EL] == '0); // R3
  AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    outValid && lastIndex |-> outResult <= MAX_EL'(lastCount)); // R10
  AST_INDEX_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    outValid && lastIndex |-> outMatch == (outResult != MAX_EL'(lastCount))); // R10
  AST_MASK_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !lastIndex |-> outMatch == (|outResult)); // R11
endmodule

bind strCmpUnit strCmpChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .modeWord  (modeWord),
  .outValid  (outValid),
  .outReady  (outReady),
  .outResult (outResult),
  .outMatch  (outMatch)
);

// File: tb/strCmpUnit_tb.sv
`timescale 1ns/1ps
module strCmpUnit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic outReady = 1'b0;
  logic [127:0] opA = '0, opB = '0;
  logic [4:0] lenA = '0, lenB = '0;
  logic [5:0] modeWord = '0;
  logic inReady, outValid, outMatch;
  logic [15:0] outResult;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;
  bit expValid = 0;
  logic [15:0] expRes = '0;
  bit expFlag = 0;
  logic [5:0] expMode = '0;
  bit randReady = 0;

  always #2 clk = ~clk;

  strCmpUnit u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opA(opA), .opB(opB), .lenA(lenA), .lenB(lenB), .modeWord(modeWord),
    .outValid(outValid), .outReady(outReady), .outResult(outResult), .outMatch(outMatch)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tagFor(input logic [5:0] m);
    string s;
    if (m[5]) s = "R10";
    else case (m[2:1])
      2'd0: s = "R5";
      2'd1: s = "R6";
      2'd2: s = "R8";
      default: s = "R7";
    endcase
    if (m[4]) s = {s, " R9"};
    if (m[0]) s = {s, " R3"};
    if (m[3]) s = {s, " R4"};
    return s;
  endfunction

  // behavioural reference: returns {flag, result}
  function automatic logic [16:0] refCalc(input logic [127:0] a, input logic [127:0] b,
                                          input int la, input int lb, input logic [5:0] m);
    int n, va, vb, idx;
    int ea[16];
    int eb[16];
    bit r;
    logic [15:0] mask;
    n = m[0] ? 8 : 16;
    mask = '0;
    for (int k = 0; k < 16; k++) begin ea[k] = 0; eb[k] = 0; end
    for (int k = 0; k < n; k++) begin
      if (m[0]) begin ea[k] = int'(a[16*k +: 16]); eb[k] = int'(b[16*k +: 16]); end
      else      begin ea[k] = int'(a[8*k +: 8]);   eb[k] = int'(b[8*k +: 8]);   end
    end
    if (m[3]) begin
      va = n; vb = n;
      for (int k = n - 1; k >= 0; k--) begin
        if (ea[k] == 0) va = k;
        if (eb[k] == 0) vb = k;
      end
    end else begin
      va = (la > n) ? n : la;
      vb = (lb > n) ? n : lb;
    end
    for (int i = 0; i < n; i++) begin
      r = 0;
      case (m[2:1])
        2'd0: if (i < vb) for (int j = 0; j < va; j++) if (ea[j] == eb[i]) r = 1;
        2'd1: if (i < va && i < vb) r = (ea[i] == eb[i]); else r = (i >= va && i >= vb);
        2'd2: if (i < vb) for (int p = 0; 2*p + 1 < va; p++)
                if (ea[2*p] <= eb[i] && eb[i] <= ea[2*p+1]) r = 1;
        default: begin
          r = (i < vb);
          for (int k = 0; k < va && i + k < vb; k++) if (ea[k] != eb[i+k]) r = 0;
        end
      endcase
      if (m[4] && i < vb) r = !r;
      mask[i] = r;
    end
    idx = n;
    for (int i = n - 1; i >= 0; i--) if (mask[i]) idx = i;
    return {(mask != 0), (m[5] ? 16'(idx) : mask)};
  endfunction

  task automatic checkOut();
    chk(outValid === expValid, "R2 outValid", 32'(outValid), 32'(expValid));
    if (expValid) begin
      chk(outResult === expRes, tagFor(expMode), 32'(outResult), 32'(expRes));
      chk(outMatch === expFlag, "R11 outMatch", 32'(outMatch), 32'(expFlag));
    end
  endtask

  task automatic step(input bit vld, input logic [127:0] a, input logic [127:0] b,
                      input logic [4:0] la, input logic [4:0] lb, input logic [5:0] m,
                      input bit rdy, output bit acc);
    @(negedge clk);
    checkOut();
    inValid = vld; opA = a; opB = b; lenA = la; lenB = lb; modeWord = m; outReady = rdy;
    #1;
    chk(inReady === (!expValid || rdy), "R2 inReady", 32'(inReady), 32'(!expValid || rdy));
    acc = vld && (!expValid || rdy);
    if (acc) begin
      {expFlag, expRes} = refCalc(a, b, int'(la), int'(lb), m);
      expMode = m;
      expValid = 1;
    end else if (rdy) expValid = 0;
  endtask

  task automatic send(input logic [127:0] a, input logic [127:0] b,
                      input logic [4:0] la, input logic [4:0] lb, input logic [5:0] m);
    bit acc;
    do step(1'b1, a, b, la, lb, m, randReady ? 1'($urandom % 2) : 1'b1, acc);
    while (!acc);
  endtask

  task automatic idle();
    bit acc;
    step(1'b0, '0, '0, '0, '0, '0, 1'b1, acc);
  endtask

  function automatic logic [127:0] mk(input string s);
    logic [127:0] v = '0;
    for (int k = 0; k < s.len() && k < 16; k++) v[8*k +: 8] = s[k];
    return v;
  endfunction

  function automatic logic [127:0] mkW(input string s);
    logic [127:0] v = '0;
    for (int k = 0; k < s.len() && k < 8; k++) v[16*k +: 16] = {8'h00, s[k]};
    return v;
  endfunction

  function automatic logic [127:0] randOp(input bit wide);
    logic [127:0] v = '0;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] c;
      c = ($urandom % 8 == 0) ? 8'h00 : 8'(8'h61 + $urandom % 3);
      if (wide && k < 8) v[16*k +: 16] = {(($urandom % 4 == 0) ? 8'h01 : 8'h00), c};
      else if (!wide)    v[8*k +: 8] = c;
    end
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(outValid === 1'b0, "R1 outValid in reset", 32'(outValid), 32'd0);
    chk(inReady === 1'b1, "R1 inReady in reset", 32'(inReady), 32'd1);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(outValid === 1'b0, "R1 outValid after reset", 32'(outValid), 32'd0);
    chk(inReady === 1'b1, "R1 inReady after reset", 32'(inReady), 32'd1);

    // mode bits: [0] wide R3, [2:1] agg, [3] implicit R4, [4] invert R9, [5] index R10
    send(mk("exyy29zz"), mk("example ex"), 5'd8, 5'd10, 6'b000000); // R5 match-any
    send(mk("exyy29zz"), mk("example ex"), 5'd8, 5'd10, 6'b000010); // R6 match-each
    send(mk("ab"), mk("xxabxxxxxxxxxxxa"), 5'd2, 5'd16, 6'b000110); // R7 partial tail at 15
    send(mk("ab"), mk("abcab"), 5'd2, 5'd4, 6'b000110);             // R7 cut by length
    send(mk("az0"), mk("Hi5z{"), 5'd3, 5'd5, 6'b000100);            // R8 odd element ignored
    send(mk("09az"), mk("Q7m"), 5'd4, 5'd3, 6'b100100);             // R8 R10 index
    send(mk("hello"), mk("help"), 5'd0, 5'd0, 6'b111010);           // R9 R4 first mismatch
    send(mk("q"), mk("abc"), 5'd1, 5'd3, 6'b100000);                // R10 no match -> 16
    send(mkW("q"), mkW("abc"), 5'd1, 5'd3, 6'b100001);              // R10 R3 no match -> 8
    send(mk(""), mk(""), 5'd0, 5'd0, 6'b000010);                    // R6 both empty
    send(mk(""), mk("abc"), 5'd0, 5'd3, 6'b000110);                 // R7 empty pattern
    send(mk("abc"), mk("cab"), 5'd31, 5'd31, 6'b000000);            // R4 saturation
    send(mkW("ba"), mkW("abcab"), 5'd31, 5'd20, 6'b000001);         // R3 R4 wide any
    send(mk("ab"), mk("abab"), 5'd2, 5'd4, 6'b011110);              // R9 R4 ordered inverted
    idle();

    randReady = 1;
    for (int t = 0; t < 600; t++) begin
      logic [5:0] m;
      m = 6'($urandom % 64);
      send(randOp(m[0]), randOp(m[0]), 5'($urandom % 20), 5'($urandom % 20), m);
    end
    randReady = 0;
    repeat (3) idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule